// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 128 pins, organised as four banks of 32. Software reaches each bank through fifteen 32-bit register slots: a pin level view, direct views of the direction and the two edge enables, and paired set and clear aliases for the output data, the direction, both edge enables and the interrupt mask. Each pin's input passes through a two-flop synchroniser, and the synchronised level feeds an edge detector. The detector records qualifying rising or falling edges in a per-bank status register, which software clears by writing ones.

The four bank windows begin at irregular offsets: three are packed four bytes apart and interleave with each other, and the fourth sits higher in the map. Within a window the register slots are 12 bytes apart. All banks drive a single shared interrupt line. The bus is a plain single-cycle write port with a combinational read path.

Top module: `pinbank_ctrl`

## Requirements
- R1: Synchronous active-low reset clears every direction, output-data, edge-enable, mask and status bit, so every pin is an input, all outputs are 0 and the interrupt is low.
- R2: Bank b's window starts at byte address 0x000, 0x004, 0x008 or 0x100 for b = 0..3, and slot k (0..14) of that window sits at window base + 12*k. Pin p of the controller is bit p mod 32 of bank p/32. An address that matches no slot reads 0 and writes nothing.
- R3: The slot order is: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status, 7 direction set, 8 direction clear, 9 rising set, 10 rising clear, 11 falling set, 12 falling clear, 13 mask set, 14 mask clear. A write to a set (clear) alias sets (clears) exactly the target bits written as 1 and leaves the others. Each alias reads back its target register.
- R4: A direction bit of 1 makes the pin an output: its output-enable bit is 1 and its output bit equals the output-data bit. With direction 0, the output-enable and output bits are 0 whatever the output data holds.
- R5: The level slot returns each pin's input after two register stages: a change on an input appears in the read value after the second rising clock edge.
- R6: A 0-to-1 change of the synchronised level on a pin whose rising enable is 1 sets its status bit on the next clock edge, three edges after the input change.
- R7: A 1-to-0 change of the synchronised level on a pin whose falling enable is 1 sets its status bit. With both enables at 1, either edge sets it.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R9: If a qualifying edge and a write of 1 to the same status bit arrive in the same cycle, the bit is set after that cycle.
- R10: The interrupt output is high exactly while some status bit of some bank is 1 and its mask bit is 1. Mask bits are set through slot 13 and cleared through slot 14.
- R11: Edges on pins whose matching enable is 0 set no status bit, and a steady input level never sets one.
- R12: Writes to slots 1, 4 and 5 replace the whole target register. Writes to the level slot are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register slot |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_i | input | 128 | Raw pin inputs |
| pin_o | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |
| irq_o | output | 1 | Shared edge interrupt |

## Verification
The bench attacks the clear-versus-edge collision by landing a status-clear write on the cycle in which a new edge arrives. A design that lets the clear win would lose that interrupt and read the bit back as 0. It also counts synchroniser stages by reading the level slot on each edge after an input change, so an extra or missing stage shows up one cycle off. It checks the interleaved low banks against the high bank at 0x100 to catch decode collisions. It writes zeros to the status slot and ones to the level slot to show that these writes leave state untouched.

// File: rtl/pinbank_pkg.sv
// Shared constants, register slot indices and the bank window map for the
// banked GPIO controller. Assumes slot order is fixed by software.
package pinbank_pkg;
    localparam int BANK_W     = 32;
    localparam int NUM_BANKS  = 4;
    localparam int ADDR_W     = 12;
    localparam int REG_STRIDE = 12;
    localparam int LOW_BANKS  = 3;
    localparam int LOW_STEP   = 4;
    localparam int HIGH_BASE  = 256;
    localparam int NREG       = 15;

    typedef enum logic [3:0] {
        RG_LEVEL, RG_DIR, RG_OUT_SET, RG_OUT_CLR, RG_RISE, RG_FALL, RG_STAT,
        RG_DIR_SET, RG_DIR_CLR, RG_RISE_SET, RG_RISE_CLR, RG_FALL_SET,
        RG_FALL_CLR, RG_MASK_SET, RG_MASK_CLR
    } reg_idx_e;

    // Byte offset of bank b's register window.
    function automatic int bank_base(input int b);
        return (b < LOW_BANKS) ? b * LOW_STEP : HIGH_BASE + (b - LOW_BANKS) * LOW_STEP;
    endfunction
endpackage

// File: rtl/pinbank_sync.sv
// Two-stage input synchroniser for a vector of independent pins.
// Assumes each bit is an unrelated asynchronous signal.
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pinbank_bank.sv
// One bank of pins: control registers with set/clear aliases, edge detect,
// write-one-to-clear status and the bank's masked interrupt request.
// Assumes sel is one-hot or zero.
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] sel,
    input  logic            we,
    input  logic [W-1:0]    wdata,
    input  logic [W-1:0]    pin_raw,
    output logic [W-1:0]    rdata,
    output logic [W-1:0]    pin_out,
    output logic [W-1:0]    pin_en,
    output logic            irq_any
);
    logic [W-1:0]    lvl, prev_q;
    logic [W-1:0]    dir_q, out_q, rise_q, fall_q, mask_q, stat_q;
    logic [W-1:0]    edge_hit, stat_clr;
    logic [NREG-1:0] wsel;
    logic [W-1:0]    view [NREG];

    pinbank_sync #(.W(W)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_raw), .q(lvl));

    assign wsel     = sel & {NREG{we}};
    assign edge_hit = (lvl & ~prev_q & rise_q) | (~lvl & prev_q & fall_q);
    assign stat_clr = wsel[RG_STAT] ? wdata : '0;

    // Control registers: direct writes replace, aliases set or clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            mask_q <= '0;
        end else begin
            if (wsel[RG_DIR])          dir_q <= wdata;
            else if (wsel[RG_DIR_SET]) dir_q <= dir_q | wdata;
            else if (wsel[RG_DIR_CLR]) dir_q <= dir_q & ~wdata;
            if (wsel[RG_OUT_SET])      out_q <= out_q | wdata;
            else if (wsel[RG_OUT_CLR]) out_q <= out_q & ~wdata;
            if (wsel[RG_RISE])           rise_q <= wdata;
            else if (wsel[RG_RISE_SET])  rise_q <= rise_q | wdata;
            else if (wsel[RG_RISE_CLR])  rise_q <= rise_q & ~wdata;
            if (wsel[RG_FALL])           fall_q <= wdata;
            else if (wsel[RG_FALL_SET])  fall_q <= fall_q | wdata;
            else if (wsel[RG_FALL_CLR])  fall_q <= fall_q & ~wdata;
            if (wsel[RG_MASK_SET])       mask_q <= mask_q | wdata;
            else if (wsel[RG_MASK_CLR])  mask_q <= mask_q & ~wdata;
        end
    end

    // Edge history and status: a new edge outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~stat_clr) | edge_hit;
        end
    end

    // Readback view: every alias returns its target register.
    always_comb begin
        view[RG_LEVEL]    = lvl;
        view[RG_DIR]      = dir_q;
        view[RG_OUT_SET]  = out_q;
        view[RG_OUT_CLR]  = out_q;
        view[RG_RISE]     = rise_q;
        view[RG_FALL]     = fall_q;
        view[RG_STAT]     = stat_q;
        view[RG_DIR_SET]  = dir_q;
        view[RG_DIR_CLR]  = dir_q;
        view[RG_RISE_SET] = rise_q;
        view[RG_RISE_CLR] = rise_q;
        view[RG_FALL_SET] = fall_q;
        view[RG_FALL_CLR] = fall_q;
        view[RG_MASK_SET] = mask_q;
        view[RG_MASK_CLR] = mask_q;
    end

    // Select the addressed slot, zero when nothing in this bank matches.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (sel[r]) rdata = rdata | view[r];
        end
    end

    assign pin_out = out_q & dir_q;
    assign pin_en  = dir_q;
    assign irq_any = |(stat_q & mask_q);

    // R3: bits written to the direction set alias are 1 afterwards.
    p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wsel[RG_DIR_SET] |=> ((dir_q & $past(wdata)) == $past(wdata)));

    // R6: a detected edge leaves its status bit set.
    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

    // R8: a written 1 with no competing edge clears the bit.
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wsel[RG_STAT] |=> ((stat_q & $past(wdata & ~edge_hit)) == '0));

    // R9: a same-cycle edge survives the clear write.
    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel[RG_STAT] && |(wdata & edge_hit))
        |=> ((stat_q & $past(wdata & edge_hit)) == $past(wdata & edge_hit)));

    // R11: no status bit rises without a detected edge.
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(edge_hit)) == '0));
endmodule

// File: rtl/pinbank_ctrl.sv
// Banked GPIO controller top: decodes the irregular bank windows, steers
// reads, slices pins per bank and merges bank requests onto one interrupt.
// Assumes a single-cycle write port and a combinational read.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [BW-1:0]    bus_wdata,
    output logic [BW-1:0]    bus_rdata,
    input  logic [NB*BW-1:0] pin_i,
    output logic [NB*BW-1:0] pin_o,
    output logic [NB*BW-1:0] pin_oe,
    output logic             irq_o
);
    localparam int NHIT = NB * NREG;

    logic [BW-1:0]   rd_bank [NB];
    logic [NB-1:0]   irq_bank;
    logic [NHIT-1:0] all_hit;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [NREG-1:0] hit;
        for (genvar r = 0; r < NREG; r++) begin : g_slot
            assign hit[r] = (bus_addr == AW'(bank_base(b) + r * REG_STRIDE));
        end
        assign all_hit[b*NREG +: NREG] = hit;

        pinbank_bank #(.W(BW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (hit),
            .we      (bus_we),
            .wdata   (bus_wdata),
            .pin_raw (pin_i[b*BW +: BW]),
            .rdata   (rd_bank[b]),
            .pin_out (pin_o[b*BW +: BW]),
            .pin_en  (pin_oe[b*BW +: BW]),
            .irq_any (irq_bank[b])
        );
    end

    // Merge bank read data; at most one bank decodes the address.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) bus_rdata = bus_rdata | rd_bank[b];
    end

    assign irq_o = |irq_bank;

    // R2: the interleaved windows never claim one address twice.
    p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_hit));
endmodule

// File: tb/pinbank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;
    localparam int NB = 4;
    localparam int BW = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  addr = 12'hFFF;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [127:0] pins = '0;
    logic [31:0]  rdata;
    logic [127:0] po, poe;
    logic         irq;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_i(pins),
        .pin_o(po), .pin_oe(poe), .irq_o(irq)
    );

    // Behavioural reference state, one word per bank.
    logic [31:0] m_dir[NB], m_out[NB], m_rise[NB], m_fall[NB], m_mask[NB];
    logic [31:0] m_stat[NB], m_s1[NB], m_s2[NB], m_prv[NB];

    function automatic int base_of(input int b);
        return (b < 3) ? b * 4 : 256;
    endfunction

    function automatic logic [11:0] A(input int b, input int r);
        return 12'(base_of(b) + 12 * r);
    endfunction

    function automatic void decode(input logic [11:0] a, output int b, output int r);
        b = -1; r = -1;
        for (int i = 0; i < NB; i++) begin
            int off;
            off = int'(a) - base_of(i);
            if (off >= 0 && off <= 168 && off % 12 == 0) begin
                b = i; r = off / 12;
            end
        end
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int b, r;
        decode(a, b, r);
        if (b < 0) return '0;
        case (r)
            0:          return m_s2[b];
            1, 7, 8:    return m_dir[b];
            2, 3:       return m_out[b];
            4, 9, 10:   return m_rise[b];
            5, 11, 12:  return m_fall[b];
            6:          return m_stat[b];
            default:    return m_mask[b];
        endcase
    endfunction

    // Reference update on each clock edge.
    always @(posedge clk) begin
        int wb, wr;
        decode(addr, wb, wr);
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                m_dir[b] = 0; m_out[b] = 0; m_rise[b] = 0; m_fall[b] = 0;
                m_mask[b] = 0; m_stat[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_prv[b] = 0;
            end else begin
                logic [31:0] edges, clr;
                edges = (m_s2[b] & ~m_prv[b] & m_rise[b]) | (~m_s2[b] & m_prv[b] & m_fall[b]);
                clr = 0;
                if (we && wb == b) begin
                    case (wr)
                        1:  m_dir[b]  = wdata;
                        2:  m_out[b]  = m_out[b] | wdata;
                        3:  m_out[b]  = m_out[b] & ~wdata;
                        4:  m_rise[b] = wdata;
                        5:  m_fall[b] = wdata;
                        6:  clr = wdata;
                        7:  m_dir[b]  = m_dir[b] | wdata;
                        8:  m_dir[b]  = m_dir[b] & ~wdata;
                        9:  m_rise[b] = m_rise[b] | wdata;
                        10: m_rise[b] = m_rise[b] & ~wdata;
                        11: m_fall[b] = m_fall[b] | wdata;
                        12: m_fall[b] = m_fall[b] & ~wdata;
                        13: m_mask[b] = m_mask[b] | wdata;
                        14: m_mask[b] = m_mask[b] & ~wdata;
                        default: ;
                    endcase
                end
                m_stat[b] = (m_stat[b] & ~clr) | edges;
                m_prv[b] = m_s2[b];
                m_s2[b] = m_s1[b];
                m_s1[b] = pins[b*BW +: BW];
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare against the reference away from the clock edge, every cycle.
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            logic [127:0] e_po, e_poe;
            logic e_irq;
            int b, r;
            e_irq = 1'b0;
            for (int i = 0; i < NB; i++) begin
                e_po[i*BW +: BW]  = m_out[i] & m_dir[i];
                e_poe[i*BW +: BW] = m_dir[i];
                if ((m_stat[i] & m_mask[i]) != 0) e_irq = 1'b1;
            end
            chk("R10", "irq_o", 128'(irq), 128'(e_irq));
            chk("R4", "pin_o", po, e_po);
            chk("R4", "pin_oe", poe, e_poe);
            decode(addr, b, r);
            if (r == 0)      chk("R5", "level read", 128'(rdata), 128'(m_read(addr)));
            else if (r == 6) chk("R6", "status read", 128'(rdata), 128'(m_read(addr)));
            else             chk("R3", "register read", 128'(rdata), 128'(m_read(addr)));
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 12'hFFF;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, "directed read", 128'(rdata), 128'(exp));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_chk(A(0, 1), 32'h0, "R1");
        rd_chk(A(3, 6), 32'h0, "R1");
        chk("R1", "irq after reset", 128'(irq), 128'(0));
        chk("R1", "oe after reset", poe, 128'(0));
        // R3 / R4: aliases and output gating
        bus_wr(A(0, 7), 32'hF0);
        bus_wr(A(0, 2), 32'h30);
        rd_chk(A(0, 1), 32'hF0, "R3");
        chk("R4", "oe low bank", poe[31:0], 128'h0F0);
        chk("R4", "out low bank", po[31:0], 128'h030);
        bus_wr(A(0, 8), 32'h10);
        rd_chk(A(0, 7), 32'hE0, "R3");
        chk("R4", "out gated by dir", po[31:0], 128'h020);
        bus_wr(A(0, 3), 32'h20);
        rd_chk(A(0, 2), 32'h10, "R3");
        chk("R4", "input pin drives 0", po[31:0], 128'h0);
        // R12: direct writes replace, level writes ignored
        bus_wr(A(3, 1), 32'hFFFF0000);
        rd_chk(A(3, 8), 32'hFFFF0000, "R12");
        bus_wr(A(0, 0), 32'hFFFFFFFF);
        rd_chk(A(0, 0), 32'h0, "R12");
        // R2: high bank window at 0x100
        bus_wr(A(3, 9), 32'h1);
        rd_chk(12'h130, 32'h1, "R2");
        rd_chk(A(1, 4), 32'h0, "R2");
        rd_chk(A(2, 4), 32'h0, "R2");
        rd_chk(12'h0FC, 32'h0, "R2");
        // R5: two-stage synchroniser latency
        addr = A(2, 0);
        pins[69] = 1'b1;
        @(negedge clk); #1;
        chk("R5", "level after one edge", 128'(rdata), 128'h0);
        @(negedge clk); #1;
        chk("R5", "level after two edges", 128'(rdata), 128'h20);
        @(negedge clk);
        // R6 / R7: rising and falling detection
        bus_wr(A(1, 9), 32'h88);
        bus_wr(A(1, 11), 32'h90);
        pins[35] = 1'b1; pins[36] = 1'b1; pins[39] = 1'b1;
        idle(4);
        rd_chk(A(1, 6), 32'h88, "R6");
        pins[35] = 1'b0; pins[36] = 1'b0; pins[39] = 1'b0;
        idle(4);
        rd_chk(A(1, 6), 32'h98, "R7");
        // R11: disabled edges and steady levels set nothing
        pins[41] = 1'b1;
        idle(5);
        rd_chk(A(1, 6), 32'h98, "R11");
        // R10: shared interrupt with mask
        chk("R10", "masked off", 128'(irq), 128'(0));
        bus_wr(A(1, 13), 32'h10);
        chk("R10", "unmasked bit4", 128'(irq), 128'(1));
        bus_wr(A(1, 14), 32'h10);
        chk("R10", "masked again", 128'(irq), 128'(0));
        bus_wr(A(2, 13), 32'hFFFFFFFF);
        chk("R10", "mask with empty status", 128'(irq), 128'(0));
        bus_wr(A(1, 13), 32'h80);
        chk("R10", "unmasked bit7", 128'(irq), 128'(1));
        // R8: write-one-to-clear
        bus_wr(A(1, 6), 32'h0);
        rd_chk(A(1, 6), 32'h98, "R8");
        bus_wr(A(1, 6), 32'h08);
        rd_chk(A(1, 6), 32'h90, "R8");
        bus_wr(A(1, 6), 32'h80);
        rd_chk(A(1, 6), 32'h10, "R8");
        chk("R8", "irq after clear", 128'(irq), 128'(0));
        // R9: edge lands in the same cycle as a clear of that bit
        pins[39] = 1'b1;
        idle(2);
        bus_wr(A(1, 6), 32'h80);
        rd_chk(A(1, 6), 32'h90, "R9");
        chk("R9", "irq kept", 128'(irq), 128'(1));
        bus_wr(A(1, 6), 32'h80);
        rd_chk(A(1, 6), 32'h10, "R8");
        // R10: high bank reaches the shared line
        bus_wr(A(3, 13), 32'h1);
        pins[96] = 1'b1;
        idle(4);
        chk("R10", "high bank irq", 128'(irq), 128'(1));
        bus_wr(A(3, 6), 32'h1);
        chk("R10", "high bank cleared", 128'(irq), 128'(0));
        idle(2);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule